// File: doc/BRIEF.md
# TDM Daisy-Chain Audio Serializer

This block drives one serial time-division multiplexed audio line toward a processor. Each device in a chain places its own four channels in the first four 32-bit slots of a frame, in the order L1, R1, L2, R2. It then passes on the stream it receives from the device upstream of it. That stream is sent 128 bit clocks (four slots) later than it arrived, so the upstream device's channels land in slots 4 to 7. Channels from devices further up the chain land in later slots.

The bit clock runs at 512 times the sample rate, which gives sixteen 32-bit slots per frame. A frame sync pulse marks the start of each frame. The four local samples are latched on the rising edge that samples the frame sync high. Each 24-bit sample sits in the upper bits of its slot, MSB first, with eight zero bits below it.

The upstream line is sampled on rising bit-clock edges. The output changes on falling edges. A controller with three states sequences the output:
- `ST_IDLE`: the state after reset; the output is held low.
- `ST_LOCAL`: the 128 local bits are sent.
- `ST_FORWARD`: the delay-line tap is sent.

Its transitions are:
- `ST_IDLE` to `ST_LOCAL` on the frame sync.
- `ST_LOCAL` to `ST_FORWARD` after the last local bit.
- `ST_FORWARD` to `ST_LOCAL` on the next frame sync.
- `ST_LOCAL` to `ST_LOCAL` on a frame sync that arrives early, which restarts the frame.

Top module: `tdm_chain_tx`

## Requirements
- R1: While reset is asserted, and after reset until the first frame sync is sampled high, `tdm_out` is 0.
- R2: Output bit positions 0 to 127 of a frame carry the local channels in slot order ch_l1 (slot 0), ch_r1 (slot 1), ch_l2 (slot 2), ch_r2 (slot 3). Each slot is 32 bits and is sent MSB first.
- R3: Within each local slot, bits 31..8 of the slot word are the 24-bit sample and bits 7..0 are 0.
- R4: Local samples are latched on the rising edge that samples `fsync` high. A change to the sample inputs later in that frame has no effect on that frame's output.
- R5: The bit sampled from `tdm_in` at frame position q is driven on `tdm_out` at position q+128. As a result, the upstream slots 0 to 3 appear in output slots 4 to 7.
- R6: Output slots 8 to 15 carry upstream slots 4 to 11 bit for bit, including any nonzero low bits.
- R7: Position 0 (the MSB of slot 0) is driven on the falling edge that follows the rising edge sampling `fsync` high. A frame sync that arrives before 512 bits restarts the frame at position 0.
- R8: With no new frame sync after 512 bits, the block stays in forwarding and keeps sending `tdm_in` delayed by 128 bit clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bclk | input | 1 | Bit clock: inputs are sampled on its rising edge, the output changes on its falling edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| fsync | input | 1 | Frame sync, one bit clock wide, once per frame |
| ch_l1 | input | 24 | Local sample for slot 0 |
| ch_r1 | input | 24 | Local sample for slot 1 |
| ch_l2 | input | 24 | Local sample for slot 2 |
| ch_r2 | input | 24 | Local sample for slot 3 |
| tdm_in | input | 1 | Serial TDM stream from the upstream device |
| tdm_out | output | 1 | Serial TDM stream toward the processor or the downstream device |

## Verification
The assertions assume that `fsync` is high for exactly one rising edge per frame and that `tdm_in` and `fsync` settle well away from the rising bit-clock edge. The bench meets this by changing every input just after a falling edge and dropping `fsync` after a single rising edge. It emulates an upstream device whose frame is aligned to the same frame sync, so the expected forwarded bits follow directly from its known slot words. Frames of 200 and 600 bits exercise the early-restart and no-sync cases.

// File: rtl/tdm_chain_pkg.sv
package tdm_chain_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_LOCAL   = 2'd1,
        ST_FORWARD = 2'd2
    } tx_state_t;

endpackage

// File: rtl/tdm_frame_ctrl.sv
module tdm_frame_ctrl
    import tdm_chain_pkg::*;
#(
    parameter int FRAME_BITS = 512,
    parameter int LOCAL_BITS = 128,
    localparam int CNT_W     = $clog2(FRAME_BITS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fsync,
    output tx_state_t        state,
    output logic [CNT_W-1:0] pos
);

    localparam logic [CNT_W-1:0] POS_LAST_LOCAL = CNT_W'(LOCAL_BITS - 1);
    localparam logic [CNT_W-1:0] POS_LAST_FRAME = CNT_W'(FRAME_BITS - 1);

    tx_state_t        state_nx;
    logic [CNT_W-1:0] pos_nx;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            pos   <= '0;
        end else begin
            state <= state_nx;
            pos   <= pos_nx;
        end
    end

    // next state and position
    always_comb begin
        state_nx = state;
        pos_nx   = pos;
        unique case (state)
            ST_IDLE: begin
                if (fsync) begin
                    state_nx = ST_LOCAL;
                    pos_nx   = '0;
                end
            end
            ST_LOCAL: begin
                if (fsync) begin
                    state_nx = ST_LOCAL;
                    pos_nx   = '0;
                end else begin
                    if (pos == POS_LAST_LOCAL) begin
                        state_nx = ST_FORWARD;
                    end
                    pos_nx = pos + 1'b1;
                end
            end
            ST_FORWARD: begin
                if (fsync) begin
                    state_nx = ST_LOCAL;
                    pos_nx   = '0;
                end else if (pos == POS_LAST_FRAME) begin
                    pos_nx = '0;
                end else begin
                    pos_nx = pos + 1'b1;
                end
            end
            default: begin
                state_nx = ST_IDLE;
                pos_nx   = '0;
            end
        endcase
    end

    AST_SYNC_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        fsync |=> (state == ST_LOCAL) && (pos == '0)); // R7

    AST_LOCAL_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOCAL) |-> (pos <= POS_LAST_LOCAL)); // R2

    AST_FORWARD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FORWARD) && !fsync |=> (state == ST_FORWARD)); // R8

    AST_LOCAL_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOCAL) && (pos == POS_LAST_LOCAL) && !fsync
        |=> (state == ST_FORWARD) && (pos == CNT_W'(LOCAL_BITS))); // R5

endmodule

// File: rtl/tdm_delay_line.sv
module tdm_delay_line #(
    parameter int DEPTH = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sdi,
    output logic tap
);

    logic [DEPTH-1:0] line_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_q <= '0;
        end else begin
            line_q <= {line_q[DEPTH-2:0], sdi};
        end
    end

    assign tap = line_q[DEPTH-1];

    AST_LINE_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (line_q[0] == $past(sdi))); // R5

endmodule

// File: rtl/tdm_slot_mux.sv
module tdm_slot_mux
    import tdm_chain_pkg::*;
#(
    parameter int LOCAL_CH  = 4,
    parameter int SAMPLE_W  = 24,
    parameter int SLOT_W    = 32,
    parameter int CNT_W     = 9,
    localparam int BIT_W    = $clog2(SLOT_W),
    localparam int CH_W     = $clog2(LOCAL_CH),
    localparam int SIDX_W   = $clog2(SAMPLE_W)
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               load,
    input  logic [LOCAL_CH-1:0][SAMPLE_W-1:0]  samples,
    input  tx_state_t                          state,
    input  logic [CNT_W-1:0]                   pos,
    input  logic                               dly_tap,
    output logic                               next_bit
);

    logic [SAMPLE_W-1:0] cap_q [LOCAL_CH];

    // one capture register per local channel
    for (genvar g = 0; g < LOCAL_CH; g++) begin : g_cap
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cap_q[g] <= '0;
            end else if (load) begin
                cap_q[g] <= samples[g];
            end
        end
    end

    logic [BIT_W-1:0]  bit_off;
    logic [CH_W-1:0]   slot_sel;
    logic [SIDX_W-1:0] smp_idx;
    logic              in_sample;
    logic              local_bit;

    assign bit_off   = pos[BIT_W-1:0];
    assign slot_sel  = pos[BIT_W +: CH_W];
    assign in_sample = (32'(bit_off) < SAMPLE_W);
    assign smp_idx   = SIDX_W'(SAMPLE_W - 1 - 32'(bit_off));

    always_comb begin
        local_bit = 1'b0;
        if (in_sample) begin
            local_bit = cap_q[slot_sel][smp_idx];
        end
    end

    always_comb begin
        unique case (state)
            ST_IDLE:    next_bit = 1'b0;
            ST_LOCAL:   next_bit = local_bit;
            ST_FORWARD: next_bit = dly_tap;
            default:    next_bit = 1'b0;
        endcase
    end

    AST_PAD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOCAL) && (32'(pos[BIT_W-1:0]) >= SAMPLE_W) |-> !next_bit); // R3

endmodule

// File: rtl/tdm_chain_tx.sv
module tdm_chain_tx
    import tdm_chain_pkg::*;
#(
    parameter int LOCAL_CH = 4,
    parameter int SAMPLE_W = 24,
    parameter int SLOT_W   = 32,
    parameter int SLOTS    = 16
) (
    input  logic                bclk,
    input  logic                rst_n,
    input  logic                fsync,
    input  logic [SAMPLE_W-1:0] ch_l1,
    input  logic [SAMPLE_W-1:0] ch_r1,
    input  logic [SAMPLE_W-1:0] ch_l2,
    input  logic [SAMPLE_W-1:0] ch_r2,
    input  logic                tdm_in,
    output logic                tdm_out
);

    localparam int FRAME_BITS = SLOTS * SLOT_W;
    localparam int LOCAL_BITS = LOCAL_CH * SLOT_W;
    localparam int CNT_W      = $clog2(FRAME_BITS);

    tx_state_t                         state;
    logic [CNT_W-1:0]                  pos;
    logic                              dly_tap;
    logic                              next_bit;
    logic [LOCAL_CH-1:0][SAMPLE_W-1:0] samples;

    assign samples = {ch_r2, ch_l2, ch_r1, ch_l1};

    tdm_frame_ctrl #(
        .FRAME_BITS (FRAME_BITS),
        .LOCAL_BITS (LOCAL_BITS)
    ) i_ctrl (
        .clk   (bclk),
        .rst_n (rst_n),
        .fsync (fsync),
        .state (state),
        .pos   (pos)
    );

    tdm_delay_line #(
        .DEPTH (LOCAL_BITS)
    ) i_dly (
        .clk   (bclk),
        .rst_n (rst_n),
        .sdi   (tdm_in),
        .tap   (dly_tap)
    );

    tdm_slot_mux #(
        .LOCAL_CH (LOCAL_CH),
        .SAMPLE_W (SAMPLE_W),
        .SLOT_W   (SLOT_W),
        .CNT_W    (CNT_W)
    ) i_mux (
        .clk      (bclk),
        .rst_n    (rst_n),
        .load     (fsync),
        .samples  (samples),
        .state    (state),
        .pos      (pos),
        .dly_tap  (dly_tap),
        .next_bit (next_bit)
    );

    // launch on the falling edge
    always_ff @(negedge bclk or negedge rst_n) begin
        if (!rst_n) begin
            tdm_out <= 1'b0;
        end else begin
            tdm_out <= next_bit;
        end
    end

    AST_IDLE_QUIET: assert property (@(posedge bclk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !tdm_out); // R1

endmodule

// File: tb/test_tdm_chain_tx.sv
module test_tdm_chain_tx;

    localparam int T_BCLK = 10;

    typedef struct packed {
        logic [23:0] l1, r1, l2, r2;
        logic [23:0] u1, u2, u3, u4;
        logic [15:0] len;
        logic        mid;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{24'h123456, 24'h89ABCD, 24'hF0E1D2, 24'h0F1E2D, 24'hA1B2C3, 24'h5D6E7F, 24'h102030, 24'hFEDCBA, 16'd512, 1'b0},
        '{24'hFFFFFF, 24'h000000, 24'h800001, 24'h7FFFFE, 24'h000000, 24'hFFFFFF, 24'h555555, 24'hAAAAAA, 16'd512, 1'b0},
        '{24'h3C3C3C, 24'hC3C3C3, 24'h010203, 24'h040506, 24'h111111, 24'h222222, 24'h333333, 24'h444444, 16'd512, 1'b1},
        '{24'h9E3779, 24'h7F4A7C, 24'h15A4E3, 24'hB5297A, 24'h6A09E6, 24'hBB67AE, 24'h3C6EF3, 24'hA54FF5, 16'd200, 1'b0},
        '{24'h0BADF0, 24'h0DCAFE, 24'hDEADBE, 24'hEF0001, 24'h246813, 24'h579BDF, 24'hECA864, 24'h20FDB9, 16'd512, 1'b0},
        '{24'h765432, 24'h10FEDC, 24'hBA9876, 24'h543210, 24'h0F0F0F, 24'hF0F0F0, 24'h00FF00, 24'hFF00FF, 16'd600, 1'b0}
    };

    logic        bclk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fsync = 1'b0;
    logic [23:0] ch_l1 = '0, ch_r1 = '0, ch_l2 = '0, ch_r2 = '0;
    logic        tdm_in = 1'b0;
    logic        tdm_out;

    int n_run  = 0;
    int n_fail = 0;
    bit prev_short = 1'b0;

    tdm_chain_tx i_tdm_chain_tx (
        .bclk    (bclk),
        .rst_n   (rst_n),
        .fsync   (fsync),
        .ch_l1   (ch_l1),
        .ch_r1   (ch_r1),
        .ch_l2   (ch_l2),
        .ch_r2   (ch_r2),
        .tdm_in  (tdm_in),
        .tdm_out (tdm_out)
    );

    always #(T_BCLK/2) bclk = ~bclk;

    function automatic logic [31:0] local_word(vec_t v, int s);
        case (s)
            0:       return {v.l1, 8'h00};
            1:       return {v.r1, 8'h00};
            2:       return {v.l2, 8'h00};
            default: return {v.r2, 8'h00};
        endcase
    endfunction

    function automatic logic [23:0] up_sample(vec_t v, int s);
        case (s)
            0:       return v.u1;
            1:       return v.u2;
            2:       return v.u3;
            default: return v.u4;
        endcase
    endfunction

    // emulated upstream device: own slots, then data from further up
    function automatic logic up_bit(vec_t v, int q);
        logic [31:0] w;
        if (q < 128) begin
            w = {up_sample(v, q / 32), 8'h00};
            return w[31 - (q % 32)];
        end else if (q < 256) begin
            w = {~up_sample(v, (q - 128) / 32), 8'hA5};
            return w[31 - (q % 32)];
        end
        return ((q >> 2) & 1) != ((q >> 6) & 1);
    endfunction

    function automatic logic exp_bit(vec_t v, int p);
        logic [31:0] w;
        if (p < 128) begin
            w = local_word(v, p / 32);
            return w[31 - (p % 32)];
        end
        return up_bit(v, p - 128);
    endfunction

    task automatic check(string tag, int slot, logic [31:0] got, logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s slot %0d got %h exp %h", tag, slot, got, exp);
        end
    endtask

    task automatic run_frame(vec_t v);
        logic [31:0] gw;
        logic [31:0] ew;
        string       tag;
        ch_l1 = v.l1; ch_r1 = v.r1; ch_l2 = v.l2; ch_r2 = v.r2;
        fsync = 1'b1;
        gw = '0;
        ew = '0;
        for (int p = 0; p < int'(v.len); p++) begin
            @(negedge bclk);
            #1;
            fsync = 1'b0;
            gw = {gw[30:0], tdm_out};
            ew = {ew[30:0], exp_bit(v, p)};
            if ((p % 32) == 31) begin
                if (p < 128) tag = v.mid ? "R4" : (prev_short ? "R7" : "R2 R3");
                else if (p < 256) tag = "R5";
                else if (p < 512) tag = "R6";
                else tag = "R8";
                check(tag, p / 32, gw, ew);
            end
            tdm_in = up_bit(v, p);
            if (v.mid && p == 5) begin
                ch_l1 = ~v.l1; ch_r1 = ~v.r1; ch_l2 = ~v.l2; ch_r2 = ~v.r2;
            end
        end
        prev_short = (v.len < 16'd512);
    endtask

    initial begin
        #(T_BCLK * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] idle_seen;
        // R1: output low under reset
        repeat (3) @(negedge bclk);
        #1;
        check("R1", 0, {31'd0, tdm_out}, 32'd0);
        rst_n = 1'b1;
        // R1: idle until first frame sync, even with upstream activity
        idle_seen = '0;
        for (int k = 0; k < 40; k++) begin
            @(negedge bclk);
            #1;
            tdm_in = k[0];
            ch_l1 = 24'hFFFFFF;
            idle_seen = idle_seen | {31'd0, tdm_out};
        end
        check("R1", 0, idle_seen, 32'd0);
        // vector table
        for (int i = 0; i < NV; i++) begin
            run_frame(VECS[i]);
        end
        // R7: frame right after a 600-bit run, then reset mid-frame
        run_frame(VECS[0]);
        rst_n = 1'b0;
        #1;
        check("R1", 0, {31'd0, tdm_out}, 32'd0);
        @(negedge bclk);
        #1;
        rst_n = 1'b1;
        idle_seen = '0;
        for (int k = 0; k < 10; k++) begin
            @(negedge bclk);
            #1;
            idle_seen = idle_seen | {31'd0, tdm_out};
        end
        check("R1", 0, idle_seen, 32'd0);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule